// File: doc/BRIEF.md
# Privileged Trap Entry and Return Sequencer

This block works out where execution goes when the core takes a fault, a trap, an interrupt or a call into privileged firmware. It also works out where execution goes when privileged code returns. The pipeline presents one event per cycle together with the current PC and the privileged base register. The sequencer then produces a registered redirect: a new PC, the next PC, and an update to the saved exception (restart) address, which the block holds itself.

Bit 0 of every PC marks privileged mode. Every vector offset has that bit set, so a handler always starts in privileged mode. A trap taken from normal mode asks the register file to switch in its shadow registers. A return whose restart address has bit 0 clear asks for the switch back. A return attempted from normal mode is refused and flagged as an illegal instruction. A small mode control register, reset to 0x6, sits alongside the sequencer.

Top module: `trap_seq`

## Requirements
- R1: After reset, `pc_q` equals the base parameter plus 1, `npc_q` equals `pc_q` plus 4, `exc_addr_q` is 0, `mctl_q` is 0x6 and every pulse output is 0.
- R2: A trap event with code 1..16 sets `pc_q` to `priv_base` plus that code's vector offset, sets `npc_q` to `pc_q` plus 4, and pulses `redir_q`. The codes and their offsets are:
  - 1 reset, 0x0001
  - 2 machine check, 0x0401
  - 3 arithmetic, 0x0501
  - 4 interrupt, 0x0101
  - 5 native data-translation miss, 0x0201
  - 6 privileged data-translation miss, 0x0281
  - 7 alignment, 0x0301
  - 8 data fault, 0x0381
  - 9 data access violation, 0x0381
  - 10 instruction-translation miss, 0x0181
  - 11 instruction-translation fault, 0x0181
  - 12 instruction access violation, 0x0081
  - 13 unimplemented opcode, 0x0481
  - 14 floating-point disabled, 0x0581
  - 15 firmware call, 0x2001
  - 16 integer overflow, 0x0501
- R3: Fault codes other than 3, 15 and 16 save the current PC unchanged as the restart address.
- R4: Arithmetic (3), firmware call (15) and integer overflow (16) save the current PC plus 4, so the faulting instruction is skipped.
- R5: An interrupt (code 4) taken while `cur_pc` bit 0 is 1 leaves `exc_addr_q` unchanged.
- R6: A nonzero-code event with `cur_pc` bit 0 equal to 0 pulses `shadow_enter_q`. The same event taken with bit 0 equal to 1 does not pulse it.
- R7: An event with code 0 redirects to `priv_base + call_tgt` and saves `cur_pc + 4`. It does not request shadow entry.
- R8: Codes 17..31 behave as code 13 (offset 0x0481, restart at `cur_pc`).
- R9: A return strobe with `cur_pc` bit 0 equal to 0 pulses `illegal_q`. It leaves `pc_q`, `npc_q` and `exc_addr_q` unchanged and gives no redirect.
- R10: A return strobe with `cur_pc` bit 0 equal to 1 sets `pc_q` to `exc_addr_q` and `npc_q` to `exc_addr_q + 4`. It pulses `redir_q` and `recheck_q`, and it pulses `shadow_exit_q` only if `exc_addr_q` bit 0 is 0.
- R11: A direct write to the restart address stores the data with bit 1 cleared. The write is ignored in a cycle that also carries an event.
- R12: A mode control write loads `mctl_q` on the next edge.
- R13: All results appear exactly one cycle after their strobe. Pulses last one cycle. With no strobe, `pc_q`, `npc_q` and `exc_addr_q` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Trap/fault/call event strobe (wins over a return) |
| evt_code | input | 5 | Event code, 0 = call to `call_tgt` |
| call_tgt | input | ADDR_W | Offset used with code 0 |
| ret_valid | input | 1 | Privileged return strobe |
| cur_pc | input | ADDR_W | PC of the instruction raising the event |
| priv_base | input | ADDR_W | Privileged base register |
| exc_we | input | 1 | Direct write of the restart address |
| exc_wdata | input | ADDR_W | Data for that write |
| mctl_we | input | 1 | Mode control write |
| mctl_wdata | input | MCTL_W | Data for that write |
| pc_q | output | ADDR_W | Redirect PC |
| npc_q | output | ADDR_W | Next PC after the redirect |
| exc_addr_q | output | ADDR_W | Saved restart address |
| redir_q | output | 1 | Redirect pulse |
| shadow_enter_q | output | 1 | Request to enable shadow registers |
| shadow_exit_q | output | 1 | Request to disable shadow registers |
| illegal_q | output | 1 | Illegal-instruction fault pulse |
| recheck_q | output | 1 | Request to re-examine pending interrupts |
| mctl_q | output | MCTL_W | Mode control register |

## Verification
Every result is one register stage away from its strobe. For each stimulus the driver pushes the expected outputs into a queue, stamped with the cycle one edge later. The monitor compares them on the falling edge of that cycle, after the design's register has settled. Idle steps that follow a strobe are checked as well, so a pulse that lasts too long or a value that drifts is caught.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;
  localparam int CODE_W     = 5;
  localparam int OFS_W      = 14;
  localparam int INSN_BYTES = 4;

  typedef enum logic [CODE_W-1:0] {
    TC_CALL      = 5'd0,
    TC_RESET     = 5'd1,
    TC_MCHK      = 5'd2,
    TC_ARITH     = 5'd3,
    TC_INTR      = 5'd4,
    TC_DTB_NAT   = 5'd5,
    TC_DTB_PRIV  = 5'd6,
    TC_ALIGN     = 5'd7,
    TC_DFAULT    = 5'd8,
    TC_DACV      = 5'd9,
    TC_ITB_MISS  = 5'd10,
    TC_ITB_FAULT = 5'd11,
    TC_IACV      = 5'd12,
    TC_UNIMP     = 5'd13,
    TC_FPDIS     = 5'd14,
    TC_FWCALL    = 5'd15,
    TC_OVF       = 5'd16
  } trap_code_e;

  // Vector offset for a code; undefined codes fall to the unimplemented vector.
  function automatic logic [OFS_W-1:0] vec_offset(input logic [CODE_W-1:0] c);
    case (c)
      TC_CALL:                  vec_offset = 14'h0000;
      TC_RESET:                 vec_offset = 14'h0001;
      TC_MCHK:                  vec_offset = 14'h0401;
      TC_ARITH, TC_OVF:         vec_offset = 14'h0501;
      TC_INTR:                  vec_offset = 14'h0101;
      TC_DTB_NAT:               vec_offset = 14'h0201;
      TC_DTB_PRIV:              vec_offset = 14'h0281;
      TC_ALIGN:                 vec_offset = 14'h0301;
      TC_DFAULT, TC_DACV:       vec_offset = 14'h0381;
      TC_ITB_MISS, TC_ITB_FAULT: vec_offset = 14'h0181;
      TC_IACV:                  vec_offset = 14'h0081;
      TC_FPDIS:                 vec_offset = 14'h0581;
      TC_FWCALL:                vec_offset = 14'h2001;
      default:                  vec_offset = 14'h0481;
    endcase
  endfunction

  // Trap-class events restart after the instruction that raised them.
  function automatic logic skips_insn(input logic [CODE_W-1:0] c);
    skips_insn = (c == TC_ARITH) || (c == TC_FWCALL) || (c == TC_OVF) || (c == TC_CALL);
  endfunction
endpackage

// File: rtl/trap_vec_lookup.sv
module trap_vec_lookup
  import trap_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] tgt,
  output logic [ADDR_W-1:0] target,
  output logic [ADDR_W-1:0] next_pc
);
  localparam int PAD_W = ADDR_W - OFS_W;

  logic [ADDR_W-1:0] ofs_ext;

  generate
    if (PAD_W <= 0) begin : g_bad_width
      $error("ADDR_W must exceed the vector offset width");
    end
  endgenerate

  always_comb begin
    ofs_ext = {{PAD_W{1'b0}}, vec_offset(code)};
    target  = base + ((code == TC_CALL) ? tgt : ofs_ext);
    next_pc = target + ADDR_W'(INSN_BYTES);
  end
endmodule

// File: rtl/trap_restart_calc.sv
module trap_restart_calc
  import trap_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              evt,
  input  logic [CODE_W-1:0] code,
  input  logic [ADDR_W-1:0] cur_pc,
  output logic              save_en,
  output logic [ADDR_W-1:0] save_val,
  output logic              shadow_req
);
  logic in_priv;

  always_comb begin
    in_priv    = cur_pc[0];
    save_en    = evt && !((code == TC_INTR) && in_priv);
    save_val   = cur_pc + (skips_insn(code) ? ADDR_W'(INSN_BYTES) : '0);
    shadow_req = evt && (code != TC_CALL) && !in_priv;
  end
endmodule

// File: rtl/trap_return_chk.sv
module trap_return_chk (
  input  logic ret,
  input  logic evt,
  input  logic cur_priv,
  input  logic exc_priv,
  output logic ret_ok,
  output logic ret_bad,
  output logic shadow_exit
);
  logic take;

  always_comb begin
    take        = ret && !evt;
    ret_ok      = take && cur_priv;
    ret_bad     = take && !cur_priv;
    shadow_exit = ret_ok && !exc_priv;
  end
endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_seq_pkg::*;
#(
  parameter int              ADDR_W   = 32,
  parameter int              MCTL_W   = 6,
  parameter logic [ADDR_W-1:0] RST_BASE = 32'h0001_0000,
  parameter logic [MCTL_W-1:0] MCTL_RST = 6'h06
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt_valid,
  input  logic [CODE_W-1:0] evt_code,
  input  logic [ADDR_W-1:0] call_tgt,
  input  logic              ret_valid,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [ADDR_W-1:0] priv_base,
  input  logic              exc_we,
  input  logic [ADDR_W-1:0] exc_wdata,
  input  logic              mctl_we,
  input  logic [MCTL_W-1:0] mctl_wdata,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] npc_q,
  output logic [ADDR_W-1:0] exc_addr_q,
  output logic              redir_q,
  output logic              shadow_enter_q,
  output logic              shadow_exit_q,
  output logic              illegal_q,
  output logic              recheck_q,
  output logic [MCTL_W-1:0] mctl_q
);
  localparam logic [ADDR_W-1:0] RST_PC  = RST_BASE + ADDR_W'(vec_offset(TC_RESET));
  localparam logic [ADDR_W-1:0] RST_NPC = RST_PC + ADDR_W'(INSN_BYTES);
  localparam logic [ADDR_W-1:0] BIT1_CLR = ~(ADDR_W'(2));

  // Named internal events
  logic [ADDR_W-1:0] trap_pc, trap_npc, save_val, ret_npc;
  logic              save_en, shadow_req, ret_ok, ret_bad, shadow_exit;
  logic              take_trap, sw_exc_write;

  trap_vec_lookup #(.ADDR_W(ADDR_W)) u_vec (
    .code    (evt_code),
    .base    (priv_base),
    .tgt     (call_tgt),
    .target  (trap_pc),
    .next_pc (trap_npc)
  );

  trap_restart_calc #(.ADDR_W(ADDR_W)) u_rst (
    .evt        (evt_valid),
    .code       (evt_code),
    .cur_pc     (cur_pc),
    .save_en    (save_en),
    .save_val   (save_val),
    .shadow_req (shadow_req)
  );

  trap_return_chk u_ret (
    .ret         (ret_valid),
    .evt         (evt_valid),
    .cur_priv    (cur_pc[0]),
    .exc_priv    (exc_addr_q[0]),
    .ret_ok      (ret_ok),
    .ret_bad     (ret_bad),
    .shadow_exit (shadow_exit)
  );

  always_comb begin
    take_trap    = evt_valid;
    sw_exc_write = exc_we && !evt_valid;
    ret_npc      = exc_addr_q + ADDR_W'(INSN_BYTES);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q           <= RST_PC;
      npc_q          <= RST_NPC;
      exc_addr_q     <= '0;
      redir_q        <= 1'b0;
      shadow_enter_q <= 1'b0;
      shadow_exit_q  <= 1'b0;
      illegal_q      <= 1'b0;
      recheck_q      <= 1'b0;
      mctl_q         <= MCTL_RST;
    end else begin
      redir_q        <= take_trap || ret_ok;
      shadow_enter_q <= shadow_req;
      shadow_exit_q  <= shadow_exit;
      illegal_q      <= ret_bad;
      recheck_q      <= ret_ok;
      if (take_trap) begin
        pc_q  <= trap_pc;
        npc_q <= trap_npc;
      end else if (ret_ok) begin
        pc_q  <= exc_addr_q;
        npc_q <= ret_npc;
      end
      if (save_en)
        exc_addr_q <= save_val;
      else if (sw_exc_write)
        exc_addr_q <= exc_wdata & BIT1_CLR;
      if (mctl_we)
        mctl_q <= mctl_wdata;
    end
  end
endmodule

// File: rtl/trap_seq_chk.sv
module trap_seq_chk
  import trap_seq_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_valid,
  input logic [CODE_W-1:0] evt_code,
  input logic              ret_valid,
  input logic [ADDR_W-1:0] cur_pc,
  input logic              exc_we,
  input logic [ADDR_W-1:0] pc_q,
  input logic [ADDR_W-1:0] npc_q,
  input logic [ADDR_W-1:0] exc_addr_q,
  input logic              redir_q,
  input logic              shadow_enter_q,
  input logic              shadow_exit_q,
  input logic              illegal_q
);
  assert_fwcall_skips_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == TC_FWCALL) |=> exc_addr_q == $past(cur_pc) + ADDR_W'(INSN_BYTES));

  assert_priv_intr_keeps_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code == TC_INTR && cur_pc[0]) |=> $stable(exc_addr_q));

  assert_user_trap_enters_shadow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_code != TC_CALL && !cur_pc[0]) |=> shadow_enter_q);

  assert_illegal_only_from_user_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |-> $past(ret_valid && !evt_valid && !cur_pc[0]));

  assert_sw_write_clears_bit1_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_we && !evt_valid) |=> !exc_addr_q[1]);

  assert_redirect_npc_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
    redir_q |-> npc_q == pc_q + ADDR_W'(INSN_BYTES));

  assert_idle_holds_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt_valid && !ret_valid && !exc_we) |=> ($stable(exc_addr_q) && $stable(pc_q) && !redir_q));

  assert_pulses_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shadow_enter_q, shadow_exit_q, illegal_q}));
endmodule

bind trap_seq trap_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .evt_valid      (evt_valid),
  .evt_code       (evt_code),
  .ret_valid      (ret_valid),
  .cur_pc         (cur_pc),
  .exc_we         (exc_we),
  .pc_q           (pc_q),
  .npc_q          (npc_q),
  .exc_addr_q     (exc_addr_q),
  .redir_q        (redir_q),
  .shadow_enter_q (shadow_enter_q),
  .shadow_exit_q  (shadow_exit_q),
  .illegal_q      (illegal_q)
);

// File: tb/trap_seq_tb.sv
`timescale 1ns/1ps
module trap_seq_tb;
  localparam logic [31:0] BASE0 = 32'h0001_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        evt_valid = 1'b0;
  logic [4:0]  evt_code = '0;
  logic [31:0] call_tgt = '0;
  logic        ret_valid = 1'b0;
  logic [31:0] cur_pc = '0;
  logic [31:0] priv_base = BASE0;
  logic        exc_we = 1'b0;
  logic [31:0] exc_wdata = '0;
  logic        mctl_we = 1'b0;
  logic [5:0]  mctl_wdata = '0;
  logic [31:0] pc_q, npc_q, exc_addr_q;
  logic        redir_q, shadow_enter_q, shadow_exit_q, illegal_q, recheck_q;
  logic [5:0]  mctl_q;

  always #4 clk = ~clk;

  trap_seq u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_code(evt_code),
    .call_tgt(call_tgt), .ret_valid(ret_valid), .cur_pc(cur_pc),
    .priv_base(priv_base), .exc_we(exc_we), .exc_wdata(exc_wdata),
    .mctl_we(mctl_we), .mctl_wdata(mctl_wdata), .pc_q(pc_q), .npc_q(npc_q),
    .exc_addr_q(exc_addr_q), .redir_q(redir_q), .shadow_enter_q(shadow_enter_q),
    .shadow_exit_q(shadow_exit_q), .illegal_q(illegal_q), .recheck_q(recheck_q),
    .mctl_q(mctl_q)
  );

  typedef struct {
    logic [31:0] pc, npc, exc;
    logic        redir, sh_in, sh_out, ill, rchk;
    logic [5:0]  mctl;
    string       tag;
    int          due;
  } exp_t;

  exp_t        sb[$];
  int          cyc = 0;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          finished = 1'b0;
  logic [15:0] vtab [0:16];
  logic [31:0] m_pc, m_npc, m_exc;
  logic [5:0]  m_mctl;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor: compare the oldest expectation on the falling edge it is due.
  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      exp_t e;
      e = sb.pop_front();
      n_checks++;
      if (pc_q !== e.pc || npc_q !== e.npc || exc_addr_q !== e.exc ||
          redir_q !== e.redir || shadow_enter_q !== e.sh_in || shadow_exit_q !== e.sh_out ||
          illegal_q !== e.ill || recheck_q !== e.rchk || mctl_q !== e.mctl) begin
        n_fail++;
        $display("FAIL %s: got pc=%h npc=%h exc=%h rd=%b si=%b so=%b il=%b rc=%b mc=%h exp pc=%h npc=%h exc=%h rd=%b si=%b so=%b il=%b rc=%b mc=%h",
          e.tag, pc_q, npc_q, exc_addr_q, redir_q, shadow_enter_q, shadow_exit_q, illegal_q,
          recheck_q, mctl_q, e.pc, e.npc, e.exc, e.redir, e.sh_in, e.sh_out, e.ill, e.rchk, e.mctl);
      end
    end
  end

  // Driver: apply one cycle of stimulus and push what must follow one edge later.
  task automatic step(input bit ev, input logic [4:0] code, input logic [31:0] tgt,
                      input bit rt, input logic [31:0] pc, input logic [31:0] base,
                      input bit ew, input logic [31:0] ewd, input bit mw,
                      input logic [5:0] mwd, input string tag);
    exp_t e;
    logic [31:0] dest;
    @(negedge clk);
    evt_valid = ev; evt_code = code; call_tgt = tgt; ret_valid = rt; cur_pc = pc;
    priv_base = base; exc_we = ew; exc_wdata = ewd; mctl_we = mw; mctl_wdata = mwd;
    e.redir = 0; e.sh_in = 0; e.sh_out = 0; e.ill = 0; e.rchk = 0;
    if (ev) begin
      if (code == 5'd0) begin
        dest  = base + tgt;
        m_exc = pc + 32'd4;
      end else begin
        dest = base + {16'h0, (code <= 5'd16) ? vtab[code] : vtab[13]};
        if (!(code == 5'd4 && pc[0]))
          m_exc = pc + ((code == 5'd3 || code == 5'd15 || code == 5'd16) ? 32'd4 : 32'd0);
        e.sh_in = !pc[0];
      end
      m_pc = dest; m_npc = dest + 32'd4; e.redir = 1;
    end else if (rt) begin
      if (!pc[0]) e.ill = 1;
      else begin
        m_pc = m_exc; m_npc = m_exc + 32'd4;
        e.redir = 1; e.rchk = 1; e.sh_out = !m_exc[0];
      end
    end
    if (!ev && ew) m_exc = ewd & 32'hFFFF_FFFD;
    if (mw) m_mctl = mwd;
    e.pc = m_pc; e.npc = m_npc; e.exc = m_exc; e.mctl = m_mctl;
    e.tag = tag; e.due = cyc + 1;
    sb.push_back(e);
  endtask

  task automatic trap(input logic [4:0] code, input logic [31:0] pc, input logic [31:0] base, input string tag);
    step(1, code, 32'h0, 0, pc, base, 0, 0, 0, 0, tag);
  endtask
  task automatic idle(input string tag);
    step(0, 0, 0, 0, 32'h0, priv_base, 0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not complete, got timeout exp completion");
      summary();
      $finish;
    end
  end

  initial begin
    vtab[0] = 16'h0000; vtab[1] = 16'h0001; vtab[2] = 16'h0401; vtab[3] = 16'h0501;
    vtab[4] = 16'h0101; vtab[5] = 16'h0201; vtab[6] = 16'h0281; vtab[7] = 16'h0301;
    vtab[8] = 16'h0381; vtab[9] = 16'h0381; vtab[10] = 16'h0181; vtab[11] = 16'h0181;
    vtab[12] = 16'h0081; vtab[13] = 16'h0481; vtab[14] = 16'h0581; vtab[15] = 16'h2001;
    vtab[16] = 16'h0501;
    m_pc = BASE0 + 32'd1; m_npc = BASE0 + 32'd5; m_exc = '0; m_mctl = 6'h06;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    n_checks++;
    if (pc_q !== m_pc || npc_q !== m_npc || exc_addr_q !== 32'h0 || mctl_q !== 6'h06 ||
        redir_q || shadow_enter_q || shadow_exit_q || illegal_q || recheck_q) begin
      n_fail++;
      $display("FAIL R1 reset: got pc=%h npc=%h exc=%h mc=%h exp pc=%h npc=%h exc=0 mc=06",
               pc_q, npc_q, exc_addr_q, mctl_q, m_pc, m_npc);
    end

    // R2, R3, R4, R6: every defined code from normal mode
    for (int c = 1; c <= 16; c++)
      trap(5'(c), 32'h0000_1000 + 32'(c) * 32'h10, BASE0, "R2_R3_R4_R6 vector from normal mode");
    idle("R13 hold after trap");
    idle("R13 second idle");
    trap(5'd4, 32'h0000_3001, BASE0, "R5 interrupt in privileged mode keeps restart");
    trap(5'd2, 32'h0000_3101, BASE0, "R6 privileged machine check no shadow request");
    step(1, 5'd0, 32'h0000_0040, 0, 32'h0000_5000, BASE0, 0, 0, 0, 0, "R7 call to target");
    trap(5'd20, 32'h0000_5100, BASE0, "R8 undefined code 20");
    trap(5'd31, 32'h0000_5201, BASE0, "R8 undefined code 31 privileged");
    step(0, 0, 0, 1, 32'h0000_6000, BASE0, 0, 0, 0, 0, "R9 return from normal mode");
    idle("R9 state unchanged after refused return");
    step(0, 0, 0, 0, 0, BASE0, 1, 32'h0000_7002, 0, 0, "R11 write clears bit 1");
    step(0, 0, 0, 1, 32'h0000_2001, BASE0, 0, 0, 0, 0, "R10 return to normal mode");
    step(0, 0, 0, 0, 0, BASE0, 1, 32'h0000_7007, 0, 0, "R11 write odd address");
    step(0, 0, 0, 1, 32'h0000_2001, BASE0, 0, 0, 0, 0, "R10 return staying privileged");
    step(1, 5'd7, 0, 0, 32'h0000_7400, BASE0, 1, 32'h0000_9990, 0, 0, "R11 write ignored with event");
    step(1, 5'd4, 0, 1, 32'h0000_7501, BASE0, 0, 0, 0, 0, "R10 event wins over return");
    step(0, 0, 0, 0, 0, BASE0, 0, 0, 1, 6'h2A, "R12 mode control write");
    idle("R12 mode control holds");
    trap(5'd15, 32'h0000_8000, 32'h0020_0000, "R4 firmware call with new base");
    trap(5'd3, 32'h0000_8101, 32'h0020_0000, "R4 arithmetic skip from privileged");
    idle("R13 pulses clear");
    idle("R13 final idle");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    summary();
    $finish;
  end
endmodule